// File: doc/BRIEF.md
# Autovectored Interrupt Level Controller

This block sits between a handful of interrupt-raising peripherals and a 68000-style processor. It holds a pending flag for each source: a horizontal-timing source at level 4, a vertical-timing source at level 6 and an external source at level 2. It drives the processor's three active-low priority inputs with the highest level that is both pending and enabled. Requests may arrive at any moment. The priority code is therefore formed from the stored flags alone and does not depend on bus activity.

When the processor runs an interrupt-acknowledge cycle, the controller pulls the valid-peripheral-address line low. The processor then takes an autovector and does not read a vector number from the data bus. The level being acknowledged is taken from the address lines. When the cycle ends, only the source at that level is cleared, and that source receives a single-clock acknowledge pulse. All inputs are synchronous to one fast clock.

Top module: `autovec_irq_ctrl`

## Requirements
- R1: During and after reset, `ipl_n_o` is 3'b111, `vpa_n_o` is 1, `ack_o` is 0 and no source is pending.
- R2: A one-clock high pulse on `req_i[i]` sets the pending flag of source i (bit 0 is horizontal at level 4, bit 1 is vertical at level 6, bit 2 is external at level 2). The flag stays set until that source is acknowledged or the block is reset.
- R3: `ipl_n_o` equals the bitwise inverse of the highest level among sources that are both pending and enabled. It is 3'b111 when no such source exists. It changes in the clock after the request edge.
- R4: When `en_i[i]` is low, source i is hidden from `ipl_n_o` but its pending flag is kept. Raising the enable again presents the level.
- R5: An interrupt-acknowledge cycle is the case where `fc_i` is 3'b111 and `as_n_i` is low. `vpa_n_o` goes low one clock after the strobe is first sampled low, and goes high one clock after the strobe is first sampled high.
- R6: `vpa_n_o` stays high for any bus cycle whose function code is not 3'b111.
- R7: At the clock where an acknowledge cycle ends, the source whose level equals `ack_lvl_i` (address bits 3:1, as last sampled during the cycle) gets a one-clock pulse on `ack_o` and its pending flag is cleared. This happens whether or not the source is enabled. Other sources are left unchanged.
- R8: If no pending source has the acknowledged level, `vpa_n_o` is still asserted during the cycle, but no acknowledge pulse is produced and no flag changes.
- R9: A new request on a source in the same clock that its acknowledge cycle ends leaves the source pending. The acknowledge pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Request pulses, one per source |
| en_i | input | NUM_SRC | Per-source enables for level presentation |
| fc_i | input | 3 | Processor function code |
| as_n_i | input | 1 | Processor address strobe, active low |
| ack_lvl_i | input | 3 | Address bits 3:1, giving the level being acknowledged |
| ipl_n_o | output | 3 | Active-low encoded interrupt priority level |
| vpa_n_o | output | 1 | Valid-peripheral-address, active low, asserted for acknowledge only |
| ack_o | output | NUM_SRC | One-clock acknowledge pulse per source |

## Verification
Two things can land in the same clock: a fresh request on a source, and the end of the acknowledge cycle that clears that same source. The bench provokes this by raising the request pulse on the very falling edge where it negates the address strobe. It then expects both an acknowledge pulse for the source and a priority code that still shows the source's level. A following acknowledge with no new request then confirms that the flag does clear and that the code falls to the next level.

// File: rtl/autovec_irq_pkg.sv
package autovec_irq_pkg;
  localparam int LVL_W = 3;
  localparam int FC_W  = 3;
  localparam logic [FC_W-1:0] FC_IACK = 3'b111;

  typedef logic [LVL_W-1:0] lvl_t;

  // Priority pins carry the level inverted.
  function automatic lvl_t lvl_to_ipl_n(input lvl_t lvl);
    return ~lvl;
  endfunction

  // An acknowledge cycle: interrupt function code with the strobe active.
  function automatic logic is_iack(input logic [FC_W-1:0] fc, input logic as_n);
    return (fc == FC_IACK) && !as_n;
  endfunction

  function automatic lvl_t pick_higher(input lvl_t a, input lvl_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/avi_iack_tracker.sv
module avi_iack_tracker
  import autovec_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FC_W-1:0] fc_i,
  input  logic            as_n_i,
  input  lvl_t            ack_lvl_i,
  output logic            vpa_n_o,
  output logic            iack_end_o,
  output lvl_t            ack_lvl_o
);
  logic iack_act;
  logic iack_q;
  logic vpa_n_q;
  lvl_t lvl_q;

  assign iack_act = is_iack(fc_i, as_n_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iack_q  <= 1'b0;
      vpa_n_q <= 1'b1;
      lvl_q   <= '0;
    end else begin
      iack_q  <= iack_act;
      vpa_n_q <= !iack_act;
      if (iack_act) lvl_q <= ack_lvl_i;
    end
  end

  assign vpa_n_o    = vpa_n_q;
  assign iack_end_o = iack_q && !iack_act;
  assign ack_lvl_o  = lvl_q;

  // R6
  vpa_iack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpa_n_o |-> $past(fc_i) == FC_IACK);

  // R5
  vpa_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_end_o |=> vpa_n_o);
endmodule

// File: rtl/avi_pending_bank.sv
module avi_pending_bank
  import autovec_irq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_LVLS = {3'd2, 3'd6, 3'd4}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               iack_end_i,
  input  lvl_t               ack_lvl_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] ack_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] ack_q;
  logic [NUM_SRC-1:0] clr_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam lvl_t SRC_LVL = SRC_LVLS[g*LVL_W +: LVL_W];

    assign clr_hit[g] = iack_end_i && (ack_lvl_i == SRC_LVL);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        ack_q[g]  <= 1'b0;
      end else begin
        // a new request outranks a clear in the same clock
        pend_q[g] <= req_i[g] || (pend_q[g] && !clr_hit[g]);
        ack_q[g]  <= clr_hit[g] && pend_q[g];
      end
    end

    // R2
    req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[g] |=> pend_o[g]);
  end

  assign pend_o = pend_q;
  assign ack_o  = ack_q;

  // R7
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));

  // R7
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != '0) |=> (ack_o == '0));
endmodule

// File: rtl/avi_level_encoder.sv
module avi_level_encoder
  import autovec_irq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_LVLS = {3'd2, 3'd6, 3'd4}
) (
  input  logic [NUM_SRC-1:0] active_i,
  output lvl_t               top_lvl_o
);
  always_comb begin
    top_lvl_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active_i[i]) top_lvl_o = pick_higher(top_lvl_o, SRC_LVLS[i*LVL_W +: LVL_W]);
    end
  end
endmodule

// File: rtl/autovec_irq_ctrl.sv
module autovec_irq_ctrl
  import autovec_irq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter logic [NUM_SRC*LVL_W-1:0] SRC_LVLS = {3'd2, 3'd6, 3'd4}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [2:0]         fc_i,
  input  logic               as_n_i,
  input  logic [2:0]         ack_lvl_i,
  output logic [2:0]         ipl_n_o,
  output logic               vpa_n_o,
  output logic [NUM_SRC-1:0] ack_o
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] visible;
  logic               iack_end;
  lvl_t               held_lvl;
  lvl_t               top_lvl;

  avi_iack_tracker u_iack (
    .clk        (clk),
    .rst_n      (rst_n),
    .fc_i       (fc_i),
    .as_n_i     (as_n_i),
    .ack_lvl_i  (ack_lvl_i),
    .vpa_n_o    (vpa_n_o),
    .iack_end_o (iack_end),
    .ack_lvl_o  (held_lvl)
  );

  avi_pending_bank #(.NUM_SRC(NUM_SRC), .SRC_LVLS(SRC_LVLS)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .iack_end_i (iack_end),
    .ack_lvl_i  (held_lvl),
    .pend_o     (pend),
    .ack_o      (ack_o)
  );

  assign visible = pend & en_i;

  avi_level_encoder #(.NUM_SRC(NUM_SRC), .SRC_LVLS(SRC_LVLS)) u_enc (
    .active_i  (visible),
    .top_lvl_o (top_lvl)
  );

  assign ipl_n_o = lvl_to_ipl_n(top_lvl);

  // R3
  ipl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (visible == '0) |-> (ipl_n_o == 3'b111));

  // R4
  ipl_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> (ipl_n_o == 3'b111));
endmodule

// File: tb/autovec_irq_ctrl_tb.sv
module autovec_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] req, en, fc, lvl;
  logic       as_n;
  logic [2:0] ipl_n;
  logic       vpa_n;
  logic [2:0] ack;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  autovec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .fc_i(fc),
    .as_n_i(as_n), .ack_lvl_i(lvl), .ipl_n_o(ipl_n), .vpa_n_o(vpa_n), .ack_o(ack)
  );

  // {req, en, expected ipl_n}; pending flags accumulate across rows
  localparam logic [8:0] VEC [8] = '{
    {3'b001, 3'b111, 3'b011},
    {3'b100, 3'b111, 3'b011},
    {3'b000, 3'b110, 3'b101},
    {3'b010, 3'b110, 3'b001},
    {3'b000, 3'b100, 3'b101},
    {3'b000, 3'b000, 3'b111},
    {3'b000, 3'b011, 3'b001},
    {3'b000, 3'b111, 3'b001}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [2:0] ipl_of(input int level);
    return ~level[2:0];
  endfunction

  task automatic do_iack(input logic [2:0] l, input int hold, input logic [2:0] req_end,
                         input logic [2:0] exp_ack, input logic [2:0] exp_ipl, input string tag);
    @(negedge clk); fc = 3'b111; as_n = 1'b0; lvl = l;
    tick();
    chk({"R5 vpa asserted ", tag}, {7'd0, vpa_n}, 8'd0);
    repeat (hold) tick();
    @(negedge clk);
    chk({"R5 vpa held ", tag}, {7'd0, vpa_n}, 8'd0);
    as_n = 1'b1; fc = 3'b000; req = req_end;
    tick();
    chk({"R5 vpa released ", tag}, {7'd0, vpa_n}, 8'd1);
    chk({"ack pulse ", tag}, {5'd0, ack}, {5'd0, exp_ack});
    @(negedge clk); req = 3'b000;
    chk({"ipl after ack ", tag}, {5'd0, ipl_n}, {5'd0, exp_ipl});
    tick();
    chk({"R7 ack one clock ", tag}, {5'd0, ack}, 8'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 0; en = 0; fc = 0; lvl = 0; as_n = 1'b1;
    repeat (3) tick();
    chk("R1 ipl reset", {5'd0, ipl_n}, 8'h07);
    chk("R1 vpa reset", {7'd0, vpa_n}, 8'd1);
    chk("R1 ack reset", {5'd0, ack}, 8'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4: table walk
    foreach (VEC[k]) begin
      @(negedge clk); req = VEC[k][8:6]; en = VEC[k][5:3];
      tick();
      @(negedge clk); req = 3'b000;
      chk($sformatf("R3 table row %0d", k), {5'd0, ipl_n}, {5'd0, VEC[k][2:0]});
    end

    // R7: acknowledge level 6, level 4 shows next
    do_iack(3'd6, 2, 3'b000, 3'b010, ipl_of(4), "R7 lvl6");

    // R6: other function code with strobe low
    @(negedge clk); fc = 3'b101; as_n = 1'b0; lvl = 3'd4;
    tick(); chk("R6 vpa stays high", {7'd0, vpa_n}, 8'd1);
    tick(); chk("R6 vpa stays high 2", {7'd0, vpa_n}, 8'd1);
    @(negedge clk); as_n = 1'b1; fc = 3'b000;
    tick(); chk("R6 no ack", {5'd0, ack}, 8'd0);
    chk("R6 ipl unchanged", {5'd0, ipl_n}, {5'd0, ipl_of(4)});

    // R9: request on level-4 source as its acknowledge ends
    do_iack(3'd4, 1, 3'b001, 3'b001, ipl_of(4), "R9 collide");
    do_iack(3'd4, 0, 3'b000, 3'b001, ipl_of(2), "R7 lvl4");

    // R8: level with no source
    do_iack(3'd5, 1, 3'b000, 3'b000, ipl_of(2), "R8 lvl5");

    // R4: mask external, then acknowledge it while masked
    @(negedge clk); en = 3'b011;
    tick(); chk("R4 masked", {5'd0, ipl_n}, 8'h07);
    do_iack(3'd2, 0, 3'b000, 3'b100, 3'b111, "R4 R7 masked ack");
    @(negedge clk); en = 3'b111;
    tick(); chk("R4 cleared while masked", {5'd0, ipl_n}, 8'h07);

    // R8: acknowledge with nothing pending
    do_iack(3'd6, 0, 3'b000, 3'b000, 3'b111, "R8 empty");

    // R1: reset with everything pending
    @(negedge clk); req = 3'b111;
    tick();
    @(negedge clk); req = 3'b000;
    chk("R2 all pending", {5'd0, ipl_n}, {5'd0, ipl_of(6)});
    rst_n = 1'b0;
    tick(); chk("R1 reset clears ipl", {5'd0, ipl_n}, 8'h07);
    @(negedge clk); rst_n = 1'b1;
    tick(); chk("R1 flags cleared", {5'd0, ipl_n}, 8'h07);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule